// File: doc/BRIEF.md
# Three-Sample Bang-Bang Phase Detector with Two-Path Loop Filter

This block sits in the digital core of a clock and data recovery loop. For each bit it takes three samples of the incoming stream: one at the bit centre, one near the expected edge, and one at the centre of the following bit. From these it decides whether the recovered clock runs ahead of or behind the data. It only decides when the two centre samples differ. When they match there was no edge, and the edge sample tells nothing.

Each decision drives two paths. The proportional path adds a fixed step of plus or minus `STEP_K` to the oscillator control word. The step lasts for exactly the one cycle that follows the decision and is then removed. The integrating path keeps a saturating signed count of decisions, so a long run of decisions in one direction moves the centre frequency. A programmable arithmetic right shift scales that count. The control word feeds a digital oscillator model. The first centre sample, retimed by one register, is the recovered data bit. An enable input from the frequency acquisition aid stops all decisions while the oscillator is being pulled back into range.

Top module: `bbpd_loop`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `out_valid`, `out_data`, `dir_up` and `dir_dn` are 0 and `ctrl_word` is 0.
- R2: A valid triplet whose centre samples are equal (`smp_a == smp_b`) gives no decision (`dir_up = dir_dn = 0`), whatever `smp_t` is.
- R3: A valid triplet with `smp_a == smp_t != smp_b` (clock early) sets `dir_dn = 1` in the next cycle.
- R4: A valid triplet with `smp_b == smp_t != smp_a` (clock late) sets `dir_up = 1` in the next cycle.
- R5: `ctrl_word` equals the scaled integrator plus `STEP_K` while `dir_up` is 1, minus `STEP_K` while `dir_dn` is 1, and plus 0 otherwise. The step is therefore gone in the cycle after a decision unless a new decision follows.
- R6: The integrator is a signed `INT_W`-bit count, 0 after reset. Each up decision adds 1 and each down decision subtracts 1. It holds at 2^(INT_W-1)-1 and at -2^(INT_W-1) instead of wrapping. A decision is already included in `ctrl_word` in the cycle where `dir_up` or `dir_dn` shows it.
- R7: The scaled integrator is the integrator shifted arithmetically right by `shift_sel` bits.
- R8: `out_valid` is `smp_valid` delayed by one cycle. `out_data` takes `smp_a` one cycle after each valid triplet and holds its value across cycles with no valid triplet.
- R9: While `acq_en` is 0, no decision is issued and the integrator does not change, whatever samples arrive.
- R10: Each cycle gives at most one decision, with one cycle of latency. A cycle with `smp_valid = 0` gives no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | The sample triplet is valid this cycle |
| smp_a | input | 1 | Sample at the centre of the current bit |
| smp_t | input | 1 | Sample near the expected transition |
| smp_b | input | 1 | Sample at the centre of the next bit |
| acq_en | input | 1 | Enable from the acquisition aid; low stops all decisions |
| shift_sel | input | SHIFT_W | Right-shift amount applied to the integrator |
| out_valid | output | 1 | Retimed data is valid |
| out_data | output | 1 | Retimed data bit (the centre sample) |
| dir_up | output | 1 | Late decision: speed the oscillator up |
| dir_dn | output | 1 | Early decision: slow the oscillator down |
| ctrl_word | output | INT_W+2 | Signed oscillator control word |

## Verification
On every cycle, the embedded assertions check these properties: the two decision flags are never high together; no decision appears after a cycle with the enable low or with no valid triplet; the retimed bit holds across invalid cycles; the integrator moves by exactly one step per decision, or stays still when no decision arrived. The bench's scenarios are needed for the rest. Only they show that each sample pattern maps to the right direction, that the proportional step appears and disappears around the integrator value, that the count saturates at both ends, and that each shift amount scales the count correctly.

// File: rtl/bbpd_pkg.sv
package bbpd_pkg;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DN   = 2'd2
  } dir_e;

  // Edge exists only when the two centre samples differ; the edge sample
  // then sides with whichever centre it matches.
  function automatic dir_e classify(input logic a, input logic t, input logic b);
    if (a == b)      return DIR_NONE;
    else if (t == a) return DIR_DN;
    else             return DIR_UP;
  endfunction

endpackage

// File: rtl/bbpd_decide.sv
module bbpd_decide
  import bbpd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smp_valid,
  input  logic smp_a,
  input  logic smp_t,
  input  logic smp_b,
  input  logic acq_en,
  output logic nudge_up,
  output logic nudge_dn,
  output logic out_valid,
  output logic out_data,
  output logic dir_up,
  output logic dir_dn
);

  dir_e cur_dir;
  dir_e dir_q;

  always_comb begin
    cur_dir = DIR_NONE;
    if (smp_valid && acq_en) cur_dir = classify(smp_a, smp_t, smp_b);
  end

  assign nudge_up = (cur_dir == DIR_UP);
  assign nudge_dn = (cur_dir == DIR_DN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q     <= DIR_NONE;
      out_valid <= 1'b0;
      out_data  <= 1'b0;
    end else begin
      dir_q     <= cur_dir;
      out_valid <= smp_valid;
      if (smp_valid) out_data <= smp_a;
    end
  end

  assign dir_up = (dir_q == DIR_UP);
  assign dir_dn = (dir_q == DIR_DN);

  a_r10_single_direction: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dir_up, dir_dn}));

  a_r9_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_en |=> !(dir_up || dir_dn));

  a_r10_decision_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_up || dir_dn) |-> out_valid);

  a_r8_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(out_data));

endmodule

// File: rtl/bbpd_integ.sv
module bbpd_integ #(
  parameter int INT_W   = 12,
  parameter int SHIFT_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inc,
  input  logic                    dec,
  input  logic [SHIFT_W-1:0]      shift_sel,
  output logic signed [INT_W-1:0] acc,
  output logic signed [INT_W-1:0] scaled
);

  localparam logic signed [INT_W-1:0] ACC_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic signed [INT_W-1:0] ACC_MIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic signed [INT_W-1:0] ONE     = INT_W'(1);

  logic at_max, at_min;
  assign at_max = (acc == ACC_MAX);
  assign at_min = (acc == ACC_MIN);

  always_ff @(posedge clk) begin
    if (!rst_n)              acc <= '0;
    else if (inc && !at_max) acc <= acc + ONE;
    else if (dec && !at_min) acc <= acc - ONE;
  end

  assign scaled = acc >>> shift_sel;

  a_r6_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !at_max) |=> (acc == $past(acc) + ONE));

  a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !at_min) |=> (acc == $past(acc) - ONE));

  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    ((inc && at_max) || (dec && at_min)) |=> $stable(acc));

  a_r9_hold_without_decision: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc || dec) |=> $stable(acc));

endmodule

// File: rtl/bbpd_loop.sv
module bbpd_loop #(
  parameter int INT_W   = 12,
  parameter int SHIFT_W = 4,
  parameter int STEP_K  = 64,
  localparam int CW     = INT_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic                 smp_a,
  input  logic                 smp_t,
  input  logic                 smp_b,
  input  logic                 acq_en,
  input  logic [SHIFT_W-1:0]   shift_sel,
  output logic                 out_valid,
  output logic                 out_data,
  output logic                 dir_up,
  output logic                 dir_dn,
  output logic signed [CW-1:0] ctrl_word
);

  localparam logic signed [CW-1:0] KSTEP = CW'(STEP_K);

  logic                    nudge_up, nudge_dn;
  logic signed [INT_W-1:0] acc, scaled;
  logic signed [CW-1:0]    prop_term;

  bbpd_decide u_decide (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .smp_a    (smp_a),
    .smp_t    (smp_t),
    .smp_b    (smp_b),
    .acq_en   (acq_en),
    .nudge_up (nudge_up),
    .nudge_dn (nudge_dn),
    .out_valid(out_valid),
    .out_data (out_data),
    .dir_up   (dir_up),
    .dir_dn   (dir_dn)
  );

  bbpd_integ #(.INT_W(INT_W), .SHIFT_W(SHIFT_W)) u_integ (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (nudge_up),
    .dec      (nudge_dn),
    .shift_sel(shift_sel),
    .acc      (acc),
    .scaled   (scaled)
  );

  always_comb begin
    prop_term = '0;
    if (dir_up)      prop_term = KSTEP;
    else if (dir_dn) prop_term = -KSTEP;
  end

  assign ctrl_word = CW'(scaled) + prop_term;

  a_r5_step_only_with_decision: assert property (@(posedge clk) disable iff (!rst_n)
    !(dir_up || dir_dn) |-> (ctrl_word == CW'(scaled)));

endmodule

// File: tb/test_bbpd_loop.sv
module test_bbpd_loop;

  localparam int IW = 6;
  localparam int SW = 3;
  localparam int K  = 5;
  localparam int CW = IW + 2;
  localparam int IMAX = (1 << (IW - 1)) - 1;
  localparam int IMIN = -(1 << (IW - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0, smp_a = 1'b0, smp_t = 1'b0, smp_b = 1'b0, acq_en = 1'b0;
  logic [SW-1:0] shift_sel = '0;
  logic out_valid, out_data, dir_up, dir_dn;
  logic signed [CW-1:0] ctrl_word;

  always #10 clk = ~clk;

  bbpd_loop #(.INT_W(IW), .SHIFT_W(SW), .STEP_K(K)) i_bbpd_loop (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_a(smp_a),
    .smp_t(smp_t), .smp_b(smp_b), .acq_en(acq_en), .shift_sel(shift_sel),
    .out_valid(out_valid), .out_data(out_data), .dir_up(dir_up),
    .dir_dn(dir_dn), .ctrl_word(ctrl_word)
  );

  typedef struct {
    logic  v;
    logic  d;
    logic  up;
    logic  dn;
    int    ctrl;
    string tag;
  } item_t;

  item_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  int m_int = 0;
  logic m_data = 1'b0;
  int sh = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic en, input logic a,
                       input logic t, input logic b, input string tag);
    item_t it;
    logic early, late;
    @(negedge clk);
    smp_valid = v; acq_en = en; smp_a = a; smp_t = t; smp_b = b;
    shift_sel = SW'(sh);
    early = v && en && (a == t) && (t != b);
    late  = v && en && (b == t) && (t != a);
    if (late && m_int < IMAX) m_int = m_int + 1;
    if (early && m_int > IMIN) m_int = m_int - 1;
    if (v) m_data = a;
    it.v = v; it.d = m_data; it.up = late; it.dn = early;
    it.ctrl = (m_int >>> sh) + (late ? K : (early ? -K : 0));
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  initial begin : monitor
    item_t e;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check(out_valid == e.v, {e.tag, " valid"}, int'(out_valid), int'(e.v));
        check(out_data == e.d, {e.tag, " data"}, int'(out_data), int'(e.d));
        check(dir_up == e.up, {e.tag, " up"}, int'(dir_up), int'(e.up));
        check(dir_dn == e.dn, {e.tag, " dn"}, int'(dir_dn), int'(e.dn));
        check(int'(ctrl_word) == e.ctrl, {e.tag, " ctrl"}, int'(ctrl_word), e.ctrl);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    check(!out_valid && !out_data, "R1 reset flags", int'(out_valid), 0);
    check(!dir_up && !dir_dn, "R1 reset dir", int'({dir_up, dir_dn}), 0);
    check(ctrl_word == 0, "R1 reset ctrl", int'(ctrl_word), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R2: no transition, T ignored
    drive(1, 1, 0, 1, 0, "R2 a=b t=1");
    drive(1, 1, 1, 0, 1, "R2 a=b t=0");
    drive(1, 1, 1, 1, 1, "R2 all ones");
    // R3: early -> down; R5 step then removal
    drive(1, 1, 1, 1, 0, "R3 early");
    drive(0, 1, 0, 0, 1, "R5 step removed R10 invalid");
    drive(1, 1, 0, 0, 1, "R3 early low");
    // R4: late -> up
    drive(1, 1, 1, 0, 0, "R4 late");
    drive(1, 1, 0, 1, 1, "R4 late low");
    drive(1, 1, 0, 0, 0, "R5 idle after up");
    // R9: disabled
    drive(1, 0, 1, 1, 0, "R9 disabled early");
    drive(1, 0, 0, 1, 1, "R9 disabled late");
    drive(1, 1, 1, 1, 1, "R9 re-enabled quiet");
    // R8: data pattern and hold
    drive(1, 1, 1, 1, 1, "R8 data one");
    drive(0, 1, 0, 0, 0, "R8 hold");
    drive(0, 1, 0, 1, 0, "R8 hold again");
    drive(1, 1, 0, 0, 0, "R8 data zero");
    // R6: saturate high
    for (int i = 0; i < IMAX + 8; i++) drive(1, 1, 1, 0, 0, "R6 sat high");
    drive(1, 1, 0, 0, 0, "R6 at max");
    // R7: shift at max
    sh = 2; drive(1, 1, 1, 1, 1, "R7 shift 2 pos");
    sh = 0;
    // R6: saturate low
    for (int i = 0; i < 2 * IMAX + 12; i++) drive(1, 1, 0, 0, 1, "R6 sat low");
    drive(1, 1, 1, 1, 1, "R6 at min");
    sh = 3; drive(1, 1, 1, 1, 1, "R7 shift 3 neg");
    sh = 1; drive(1, 1, 1, 0, 0, "R7 shift 1 with up");
    sh = 7; drive(1, 1, 0, 0, 0, "R7 shift 7");
    sh = 0;
    drive(0, 1, 0, 0, 0, "R10 flush");
    repeat (3) @(posedge clk);
    #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule